// File: doc/BRIEF.md
# Binary Galois Field Arithmetic Unit

This block performs arithmetic in a binary extension field GF(2^n) whose degree and reduction polynomial are supplied with every request. It accepts one request at a time on a valid/ready handshake carrying an opcode, three operands, the degree and the modulus. It returns a result together with a one-cycle done strobe.

Four operations are provided:

- a field product reduced by the modulus;
- the upper half of the unreduced carry-less product;
- a fused multiply-add;
- the multiplicative inverse, with zero mapped to zero.

Field addition is a plain XOR, so the surrounding logic does it without this unit.

The unit is a multi-cycle state machine, not a pipeline. A shared shift-and-XOR engine consumes a fixed number of multiplier bits per clock and stops as soon as the remaining multiplier bits are all zero. The inverse is computed by raising the operand to the power 2^n − 2 through repeated squaring and multiplication on the same engine.

Top module: `gfu_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done` is 0.
- R2: Handshake.
  - A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
  - `req_ready` is 0 from the cycle after that edge up to and including the done cycle.
  - `req_ready` returns to 1 in the cycle after the done cycle.
- R3: Every accepted request produces exactly one `rsp_done` pulse, one cycle long. `rsp_result` is valid in that cycle.
- R4: Opcode 0 returns a·b reduced modulo `req_poly`.
  - `req_poly` holds the full modulus, including bit `req_deg`.
  - The result never has bits at or above `req_deg`.
- R5: Opcode 1 returns the carry-less product of a and b shifted right by `req_deg` and masked to `req_deg` bits.
- R6: Opcode 2 returns (a·b mod poly) XOR c. This is the multiply-add with c as the addend.
- R7: Opcode 3 returns the inverse a^(2^n−2).
  - For nonzero a in a field with an irreducible modulus, the result times a is 1.
  - An input of zero gives zero, with done in the cycle after acceptance and no error indication.
- R8: Opcode values 4 to 7 give a zero result, with done in the cycle right after acceptance.
- R9: Operand bits at or above `req_deg` in a, b and c have no effect on the result or on the timing.
- R10: Every degree from 1 to 64 is supported. Degree 64 uses the full operand width, and degree 1 works with the modulus x+1.
- R11: For opcodes 0 to 2, done is asserted k+1 clock edges after the accepting edge.
  - k = ceil(h/2), where h is the bit length of the masked multiplier b.
  - k = 0 when b is zero.
  - This relies on two multiplier bits being consumed per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | Opcode: 0 multiply, 1 upper half, 2 multiply-add, 3 inverse |
| req_a | input | 64 | First operand (multiplicand, or the value to invert) |
| req_b | input | 64 | Second operand (multiplier) |
| req_c | input | 64 | Addend for multiply-add |
| req_deg | input | 7 | Field degree n, 1 to 64 |
| req_poly | input | 65 | Reduction polynomial, including bit n |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_result | output | 64 | Result, valid with the strobe |

## Verification
The assertions assume that every accepted request has a degree between 1 and 64. They also assume that, for the reducing opcodes, the modulus has bit n set and no bits above it; the multiplicand then stays inside the field on every step. The inverse result is only meaningful when that modulus is irreducible. The stimulus therefore uses only x+1 for degree 1, 0x11B for degree 8, and x^64+x^4+x^3+x+1 for degree 64, while the operand bits above the degree are filled with random noise.

// File: rtl/gfu_pkg.sv
// Package gfu_pkg: opcode values and controller states for the GF(2^n) unit.
// Assumes a 3-bit opcode field; values 4..7 are reserved and yield zero.
package gfu_pkg;

    localparam int OPW = 3;

    localparam logic [OPW-1:0] OP_MUL  = 3'd0;
    localparam logic [OPW-1:0] OP_MULH = 3'd1;
    localparam logic [OPW-1:0] OP_MADD = 3'd2;
    localparam logic [OPW-1:0] OP_INV  = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_INV_SQ,
        ST_INV_ML,
        ST_DONE
    } gfu_state_t;

endpackage

// File: rtl/gfu_mask.sv
// Module gfu_mask: builds a mask with the low 'deg' bits set.
// Assumes deg <= W; any larger value yields all ones.
module gfu_mask #(
    parameter int W  = 64,
    parameter int DW = $clog2(W + 1)
) (
    input  logic [DW-1:0] deg,
    output logic [W-1:0]  mask
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Mask generation: saturate at full width, otherwise 2^deg - 1.
    always_comb begin
        if (int'(deg) >= W) mask = '1;
        else                mask = (ONE << deg) - ONE;
    end
endmodule

// File: rtl/gfu_step.sv
// Module gfu_step: one shift-and-XOR stage of the carry-less multiply.
// When the multiplier bit is set, the multiplicand is added into the accumulator.
// The multiplicand is then shifted left by one. In reducing mode it is folded
// back by the modulus whenever bit deg becomes set.
// Assumes poly has bit deg set and no bits above it.
module gfu_step #(
    parameter int W  = 64,
    parameter int DW = $clog2(W + 1)
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [2*W-1:0] mc_i,
    input  logic           bit_i,
    input  logic           reduce_i,
    input  logic [W:0]     poly_i,
    input  logic [DW-1:0]  deg_i,
    output logic [2*W-1:0] acc_o,
    output logic [2*W-1:0] mc_o
);
    logic [2*W-1:0] shifted;

    // Stage datapath: conditional accumulate, then shift with optional fold.
    always_comb begin
        acc_o   = bit_i ? (acc_i ^ mc_i) : acc_i;
        shifted = mc_i << 1;
        if (reduce_i && shifted[deg_i])
            shifted = shifted ^ {{(W-1){1'b0}}, poly_i};
        mc_o = shifted;
    end
endmodule

// File: rtl/gfu_engine.sv
// Module gfu_engine: iterative carry-less multiplier with early exit.
// A start pulse loads x (multiplicand) and y (multiplier).
// Each clock then consumes STEPS multiplier bits through a chain of gfu_step
// stages. run drops once no multiplier bits remain, and prod is final from the
// first cycle in which run is low.
// Assumes STEPS <= W, and that poly and deg stay stable while run is high.
module gfu_engine #(
    parameter int W     = 64,
    parameter int DW    = $clog2(W + 1),
    parameter int STEPS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           reduce,
    input  logic [W:0]     poly,
    input  logic [DW-1:0]  deg,
    output logic           run,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc_q, mc_q;
    logic [W-1:0]  mb_q;
    logic          red_q, run_q;
    logic [PW-1:0] acc_c [STEPS+1];
    logic [PW-1:0] mc_c  [STEPS+1];
    logic [W-1:0]  mb_next;

    assign acc_c[0] = acc_q;
    assign mc_c[0]  = mc_q;
    assign mb_next  = mb_q >> STEPS;

    for (genvar g = 0; g < STEPS; g++) begin : g_stage
        gfu_step #(.W(W), .DW(DW)) u_step (
            .acc_i    (acc_c[g]),
            .mc_i     (mc_c[g]),
            .bit_i    (mb_q[g]),
            .reduce_i (red_q),
            .poly_i   (poly),
            .deg_i    (deg),
            .acc_o    (acc_c[g+1]),
            .mc_o     (mc_c[g+1])
        );
    end

    // Engine registers: load on start, advance STEPS bits per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            mb_q  <= '0;
            red_q <= 1'b0;
            run_q <= 1'b0;
        end else if (start) begin
            acc_q <= '0;
            mc_q  <= {{W{1'b0}}, x};
            mb_q  <= y;
            red_q <= reduce;
            run_q <= |y;
        end else if (run_q) begin
            acc_q <= acc_c[STEPS];
            mc_q  <= mc_c[STEPS];
            mb_q  <= mb_next;
            run_q <= |mb_next;
        end
    end

    assign run  = run_q;
    assign prod = acc_q;

    // R4
    acc_in_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && red_q) |-> ((acc_q >> deg) == '0));

    // R4
    mc_in_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && red_q) |-> ((mc_q >> deg) == '0));
endmodule

// File: rtl/gfu_unit.sv
// Module gfu_unit: request-level controller of the GF(2^n) arithmetic unit.
// It accepts one request while idle and masks the operands to the degree.
// It sequences the shared multiply engine:
//   - one pass for multiply, upper-half multiply and multiply-add;
//   - alternating square and multiply passes for the inverse.
// It reports through a registered done pulse and result.
// Assumes req_deg is in 1..W and that req_poly has bit req_deg set for
// the reducing opcodes.
module gfu_unit
    import gfu_pkg::*;
#(
    parameter int W     = 64,
    parameter int STEPS = 2,
    localparam int DW   = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [OPW-1:0] req_op,
    input  logic [W-1:0]   req_a,
    input  logic [W-1:0]   req_b,
    input  logic [W-1:0]   req_c,
    input  logic [DW-1:0]  req_deg,
    input  logic [W:0]     req_poly,
    output logic           rsp_done,
    output logic [W-1:0]   rsp_result
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    gfu_state_t     state_q;
    logic [OPW-1:0] op_q;
    logic [W-1:0]   c_q, x_q, r_q, res_q;
    logic [DW-1:0]  deg_q, k_q;
    logic [W:0]     poly_q;

    logic [W-1:0]   mask_in, mask_run, a_m, b_m, c_m, mulh_val;
    logic [W:0]     poly_m;
    logic           accept;
    logic           eng_start, eng_red, eng_run;
    logic [W-1:0]   eng_x, eng_y;
    logic [2*W-1:0] eng_prod, hi_shift;

    gfu_mask #(.W(W), .DW(DW)) u_mask_in  (.deg(req_deg), .mask(mask_in));
    gfu_mask #(.W(W), .DW(DW)) u_mask_run (.deg(deg_q),   .mask(mask_run));

    gfu_engine #(.W(W), .DW(DW), .STEPS(STEPS)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .x      (eng_x),
        .y      (eng_y),
        .reduce (eng_red),
        .poly   (accept ? poly_m : poly_q),
        .deg    (accept ? req_deg : deg_q),
        .run    (eng_run),
        .prod   (eng_prod)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign a_m       = req_a & mask_in;
    assign b_m       = req_b & mask_in;
    assign c_m       = req_c & mask_in;
    assign poly_m    = req_poly & {mask_in, 1'b1};
    assign hi_shift  = eng_prod >> deg_q;
    assign mulh_val  = hi_shift[W-1:0] & mask_run;

    // Engine launch: picks the operands of the next multiply pass.
    always_comb begin
        eng_start = 1'b0;
        eng_red   = 1'b1;
        eng_x     = '0;
        eng_y     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_op == OP_MUL || req_op == OP_MADD || req_op == OP_MULH) begin
                        eng_start = 1'b1;
                        eng_red   = (req_op != OP_MULH);
                        eng_x     = a_m;
                        eng_y     = b_m;
                    end else if (req_op == OP_INV && a_m != '0 && int'(req_deg) > 1) begin
                        eng_start = 1'b1;
                        eng_x     = a_m;
                        eng_y     = a_m;
                    end
                end
            end
            ST_INV_SQ: begin
                if (!eng_run) begin
                    eng_start = 1'b1;
                    eng_x     = r_q;
                    eng_y     = eng_prod[W-1:0];
                end
            end
            ST_INV_ML: begin
                if (!eng_run && int'(k_q) > 1) begin
                    eng_start = 1'b1;
                    eng_x     = x_q;
                    eng_y     = x_q;
                end
            end
            default: ;
        endcase
    end

    // Controller: request capture, pass sequencing and result formation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            c_q     <= '0;
            x_q     <= '0;
            r_q     <= '0;
            k_q     <= '0;
            deg_q   <= '0;
            poly_q  <= '0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q   <= req_op;
                        c_q    <= c_m;
                        deg_q  <= req_deg;
                        poly_q <= poly_m;
                        r_q    <= ONE;
                        k_q    <= req_deg - 1'b1;
                        if (req_op == OP_MUL || req_op == OP_MULH || req_op == OP_MADD) begin
                            state_q <= ST_MUL;
                        end else if (req_op == OP_INV) begin
                            if (a_m == '0) begin
                                res_q   <= '0;
                                state_q <= ST_DONE;
                            end else if (int'(req_deg) <= 1) begin
                                res_q   <= a_m;
                                state_q <= ST_DONE;
                            end else begin
                                state_q <= ST_INV_SQ;
                            end
                        end else begin
                            res_q   <= '0;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_MUL: begin
                    if (!eng_run) begin
                        if (op_q == OP_MULH)      res_q <= mulh_val;
                        else if (op_q == OP_MADD) res_q <= eng_prod[W-1:0] ^ c_q;
                        else                      res_q <= eng_prod[W-1:0];
                        state_q <= ST_DONE;
                    end
                end
                ST_INV_SQ: begin
                    if (!eng_run) begin
                        x_q     <= eng_prod[W-1:0];
                        state_q <= ST_INV_ML;
                    end
                end
                ST_INV_ML: begin
                    if (!eng_run) begin
                        r_q <= eng_prod[W-1:0];
                        k_q <= k_q - 1'b1;
                        if (int'(k_q) <= 1) begin
                            res_q   <= eng_prod[W-1:0];
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_INV_SQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_done   = (state_q == ST_DONE);
    assign rsp_result = res_q;

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R2
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready);

    // R3
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R3
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    // R8
    reserved_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op > OP_INV) |=> (rsp_done && rsp_result == '0));

    // R7
    inverse_of_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_INV && a_m == '0) |=> (rsp_done && rsp_result == '0));

    // R9
    result_in_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ((rsp_result & ~mask_run) == '0));

    // R10
    degree_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (int'(req_deg) >= 1 && int'(req_deg) <= W));

    // R4
    modulus_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op != OP_MULH && req_op <= OP_INV) |-> req_poly[req_deg]);
endmodule

// File: tb/gfu_unit_test.sv
// Bench gfu_unit_test: behavioural model of the GF(2^n) unit.
// The expected result is computed with a full carry-less product followed by
// top-down long division. The expected done cycle comes from the bit length
// of the multiplier. The handshake is compared on every clock.
module gfu_unit_test;
    localparam int W  = 64;
    localparam int DW = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [2:0]    req_op;
    logic [W-1:0]  req_a, req_b, req_c;
    logic [DW-1:0] req_deg;
    logic [W:0]    req_poly;
    logic          rsp_done;
    logic [W-1:0]  rsp_result;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    localparam logic [W:0] P1  = 65'h3;
    localparam logic [W:0] P8  = 65'h11B;
    localparam logic [W:0] P64 = {1'b1, 64'h1B};

    always #10 clk = ~clk;

    gfu_unit #(.W(W), .STEPS(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_a(req_a), .req_b(req_b), .req_c(req_c),
        .req_deg(req_deg), .req_poly(req_poly), .rsp_done(rsp_done),
        .rsp_result(rsp_result)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fmask(input int deg);
        if (deg >= W) return '1;
        return (64'd1 << deg) - 64'd1;
    endfunction

    function automatic logic [2*W-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] r = '0;
        for (int i = 0; i < W; i++)
            if (b[i]) r = r ^ ({{W{1'b0}}, a} << i);
        return r;
    endfunction

    function automatic logic [W-1:0] model_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input int deg, input logic [W:0] poly);
        logic [2*W-1:0] p = clmul(a & fmask(deg), b & fmask(deg));
        for (int i = 2*W-2; i >= deg; i--)
            if (p[i]) p = p ^ ({{(W-1){1'b0}}, poly} << (i - deg));
        return p[W-1:0];
    endfunction

    function automatic int exp_lat(input logic [W-1:0] b, input int deg);
        logic [W-1:0] bm = b & fmask(deg);
        int h = 0;
        for (int i = 0; i < W; i++) if (bm[i]) h = i + 1;
        return (h + 1) / 2 + 2;
    endfunction

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // Issue one request, compare ready on every clock, time the done pulse.
    // lat: negedge count at which done is expected, or -1 when not timed.
    task automatic run_op(input string tag, input logic [2:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W-1:0] c, input int deg,
                          input logic [W:0] poly, input int lat, output logic [W-1:0] res);
        int n = 1;
        check({tag, " R2 ready before request"}, W'(req_ready), 1);
        req_op = op; req_a = a; req_b = b; req_c = c;
        req_deg = DW'(deg); req_poly = poly; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_a = rnd64(); req_b = rnd64(); req_c = rnd64();
        while (rsp_done !== 1'b1 && n < 40000) begin
            check({tag, " R2 ready low while busy"}, W'(req_ready), 0);
            @(negedge clk);
            n++;
        end
        check({tag, " R3 done seen"}, W'(rsp_done), 1);
        if (lat >= 0) check({tag, " R11 done cycle"}, W'(n), W'(lat));
        check({tag, " R2 ready low in done cycle"}, W'(req_ready), 0);
        res = rsp_result;
        @(negedge clk);
        check({tag, " R3 done is one cycle"}, W'(rsp_done), 0);
        check({tag, " R2 ready after done"}, W'(req_ready), 1);
    endtask

    // Run one multiply-class opcode and compare against the model.
    task automatic mul_case(input string tag, input logic [2:0] op, input logic [W-1:0] a,
                            input logic [W-1:0] b, input logic [W-1:0] c, input int deg,
                            input logic [W:0] poly);
        logic [W-1:0] res, exp;
        logic [2*W-1:0] full;
        logic [W-1:0] msk = fmask(deg);
        full = clmul(a & msk, b & msk) >> deg;
        if (op == 3'd1)      exp = full[W-1:0] & msk;
        else if (op == 3'd2) exp = model_mul(a, b, deg, poly) ^ (c & msk);
        else                 exp = model_mul(a, b, deg, poly);
        run_op(tag, op, a, b, c, deg, poly, exp_lat(b, deg), res);
        check(tag, res, exp);
    endtask

    // Run an inverse and check that its product with the input is one.
    task automatic inv_case(input string tag, input logic [W-1:0] a, input int deg,
                            input logic [W:0] poly);
        logic [W-1:0] res;
        run_op(tag, 3'd3, a, '0, '0, deg, poly, -1, res);
        check({tag, " R7 product with input"}, model_mul(a, res, deg, poly), 1);
        check({tag, " R9 result inside field"}, res & ~fmask(deg), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] res;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_a = '0; req_b = '0;
        req_c = '0; req_deg = DW'(8); req_poly = P8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 ready after reset", W'(req_ready), 1);
        check("R1 done after reset", W'(rsp_done), 0);

        // R4: known field product, degree 8
        mul_case("R4 aes product", 3'd0, 64'h57, 64'h83, 0, 8, P8);
        run_op("R4 aes fixed", 3'd0, 64'h57, 64'h83, 0, 8, P8, exp_lat(64'h83, 8), res);
        check("R4 0x57*0x83", res, 64'hC1);
        // R7: known inverse and zero input
        run_op("R7 aes inverse", 3'd3, 64'h53, 0, 0, 8, P8, -1, res);
        check("R7 inverse of 0x53", res, 64'hCA);
        run_op("R7 zero deg8", 3'd3, 64'h0, 0, 0, 8, P8, 1, res);
        check("R7 inverse of zero deg8", res, 0);
        run_op("R7 zero masked", 3'd3, 64'hFFFF_FF00, 0, 0, 8, P8, 1, res);
        check("R7 R9 zero after masking", res, 0);
        run_op("R7 zero deg64", 3'd3, 64'h0, 0, 0, 64, P64, 1, res);
        check("R7 inverse of zero deg64", res, 0);
        // R8: reserved opcodes
        run_op("R8 op5", 3'd5, rnd64(), rnd64(), rnd64(), 8, P8, 1, res);
        check("R8 op5 result", res, 0);
        run_op("R8 op7", 3'd7, rnd64(), rnd64(), rnd64(), 64, P64, 1, res);
        check("R8 op7 result", res, 0);
        // R10: degree 1
        mul_case("R10 deg1 mul", 3'd0, 64'h1, 64'h1, 0, 1, P1);
        run_op("R10 deg1 inverse", 3'd3, 64'h1, 0, 0, 1, P1, 1, res);
        check("R10 deg1 inverse value", res, 1);
        // R11: zero multiplier finishes after one edge past acceptance
        mul_case("R11 zero multiplier", 3'd0, 64'hAB, 64'h0, 0, 8, P8);
        mul_case("R11 single bit", 3'd0, rnd64(), 64'h1, 0, 64, P64);
        mul_case("R11 top bit", 3'd2, rnd64(), 64'h8000_0000_0000_0000, rnd64(), 64, P64);
        // R9: noise above the degree
        mul_case("R9 noisy operands", 3'd2, 64'hDEAD_BE00 | 64'h35, 64'hFFFF_0000_0000_0002,
                 64'hFFFF_FFFF_FFFF_FF11, 8, P8);
        mul_case("R9 R5 noisy upper half", 3'd1, 64'hF0F0_F0F0_F0F0_F0FF,
                 64'h1234_5678_9ABC_DEFF, 0, 8, P8);

        // R4 R5 R6 random, degree 8
        for (int i = 0; i < 30; i++) begin
            logic [2:0] op = 3'(i % 3);
            mul_case(op == 0 ? "R4 rand8" : op == 1 ? "R5 rand8" : "R6 rand8",
                     op, rnd64(), rnd64(), rnd64(), 8, P8);
        end
        // R4 R5 R6 R10 random, degree 64
        for (int i = 0; i < 30; i++) begin
            logic [2:0] op = 3'(i % 3);
            mul_case(op == 0 ? "R4 R10 rand64" : op == 1 ? "R5 R10 rand64" : "R6 R10 rand64",
                     op, rnd64(), rnd64(), rnd64(), 64, P64);
        end
        mul_case("R5 full ones", 3'd1, '1, '1, 0, 64, P64);
        // R7 random inverses
        for (int i = 0; i < 10; i++) begin
            logic [W-1:0] a = rnd64();
            if ((a & 64'hFF) == 0) a = a | 64'h1;
            inv_case("R7 rand8", a, 8, P8);
        end
        for (int i = 0; i < 2; i++) inv_case("R7 R10 rand64", rnd64() | 64'h1, 64, P64);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule